// File: doc/BRIEF.md
# Double-Precision Round and Pack Unit

This block turns an unpacked double-precision intermediate result into a packed 64-bit IEEE-754 double and a small set of exception flags. An arithmetic datapath upstream hands over a sign, a signed unbiased exponent and a wide mantissa. In that mantissa the weight 2^0 sits at bit 55, the 52 fraction bits lie directly beneath it, and three extra bits below the result LSB carry guard and sticky information. The unit first normalizes the mantissa with a priority encoder and a barrel shift, with any bits lost on a right shift folded into a sticky bit. It then handles the tiny-exponent case, rounds in one of four modes, checks for overflow after rounding, and packs the result.

Two trap-enable inputs choose how range errors are reported. With the overflow trap disabled, an overflow yields infinity or the largest finite magnitude, depending on the rounding mode and the sign. With it enabled, the exponent is rebiased downward by 1536 and the result is packed normally. With the underflow trap disabled, a tiny result is shifted down into a denormal. With it enabled, the exponent is rebiased upward by 1536. The whole computation takes one cycle. The result is held in a single output register behind a valid/ready handshake.

Top module: `dp_round_pack`

## Requirements
- R1: A finite, in-range result is packed as sign in bit 63, biased exponent (unbiased + 1023) in bits 62..52, and fraction in bits 51..0. A result whose bit of weight 2^0 is clear after the denormal shift gets a stored exponent field of 0.
- R2: The input mantissa is normalized so that its leading one moves to bit 55, adjusting the exponent by the shift distance. Bits shifted out on a right shift are ORed into bit 0.
- R3: in_rmode selects the rounding: 0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity.
- R4: In nearest mode an exact half-way tie rounds to the candidate whose fraction LSB is 0.
- R5: out_flags is {overflow, underflow, inexact} in bits 2, 1, 0. Inexact is set whenever any of the three bits below the result LSB is nonzero.
- R6: If the unbiased exponent exceeds 1023 and the overflow trap is off, the result depends on mode and sign. Nearest gives infinity; toward zero gives 0x7FEFFFFFFFFFFFFF in magnitude. Toward plus infinity gives infinity for positive and the largest finite value for negative results; toward minus infinity does the reverse. The sign is kept, and flags read overflow and inexact.
- R7: If the exponent exceeds 1023 and the overflow trap is on, 1536 is subtracted from the exponent before packing, and flags read overflow and inexact.
- R8: If the exponent is below -1022 and the underflow trap is on, 1536 is added to the exponent before packing, and flags read underflow and inexact.
- R9: If the exponent is below -1022 and the underflow trap is off, the mantissa is shifted right until the exponent is -1022, with shifted-out bits ORed into bit 0, and the result is then rounded as a denormal.
- R10: In the R9 case the underflow flag is set when all bits from 55 down to 3 are zero after that shift.
- R11: A zero input mantissa yields a zero carrying the input sign and no flags.
- R12: A rounding carry out of the mantissa increments the exponent, and the overflow check of R6/R7 applies to the incremented value.
- R13: in_ready is high when the output register is empty or being drained. An accepted input appears on the outputs on the next cycle. A held output (out_valid high, out_ready low) stays stable.
- R14: After reset out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Intermediate result offered |
| in_ready | output | 1 | Unit can take an input this cycle |
| in_sign | input | 1 | Sign of the intermediate |
| in_exp | input | EXP_W | Signed unbiased exponent (two's complement) |
| in_mant | input | MANT_W | Mantissa, weight 2^0 at bit 55 |
| in_rmode | input | 2 | Rounding mode (R3) |
| in_ovf_trap | input | 1 | Overflow trap enable |
| in_unf_trap | input | 1 | Underflow trap enable |
| out_valid | output | 1 | Packed result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Packed double |
| out_flags | output | 3 | {overflow, underflow, inexact} |

## Verification
The assertions assume that the mantissa, exponent, mode and trap inputs are driven to known values whenever in_valid is high. They also assume that a stalled consumer keeps out_ready low only while it actually holds off the result. The exponent is assumed to stay inside the EXP_W range, so that the internal widened exponent cannot wrap. The stimulus sets every input field at each transfer and uses exponents no further out than a few hundred steps past each range limit. It drops in_valid between transfers, except in the one stall scenario, which deliberately presents a second operand against a full output register.

// File: rtl/dprp_pkg.sv
package dprp_pkg;
  localparam int LEAD     = 55;
  localparam int GRS      = 3;
  localparam int FRAC_W   = 52;
  localparam int EF_W     = 11;
  localparam int BIAS     = 1023;
  localparam int EMAX     = 1023;
  localparam int EMIN     = -1022;
  localparam int REBIAS   = 1536;
  localparam int RES_W    = 64;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_PINF = 2'd2,
    RM_NINF = 2'd3
  } rmode_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inx;
  } flags_t;
endpackage

// File: rtl/dprp_norm.sv
module dprp_norm
  import dprp_pkg::*;
#(
  parameter int MANT_W = 64,
  parameter int EXP_W  = 13,
  parameter int IEW    = EXP_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chk_en,
  input  logic [MANT_W-1:0]     mant_i,
  input  logic [EXP_W-1:0]      exp_i,
  output logic [MANT_W-1:0]     mant_o,
  output logic signed [IEW-1:0] exp_o,
  output logic                  zero_o
);
  localparam int PW = $clog2(MANT_W);
  localparam logic [PW-1:0] LEAD_P = PW'(LEAD);
  localparam logic signed [IEW-1:0] LEAD_S = IEW'(LEAD);

  logic [PW-1:0]         lead_pos;
  logic [PW-1:0]         shamt;
  logic signed [IEW-1:0] pos_s;
  logic signed [IEW-1:0] exp_ext;
  logic                  lost;

  // priority encoder: highest set bit wins
  always_comb begin
    lead_pos = '0;
    for (int i = 0; i < MANT_W; i++) begin
      if (mant_i[i]) lead_pos = PW'(i);
    end
  end

  assign zero_o  = (mant_i == '0);
  assign pos_s   = IEW'(lead_pos);
  assign exp_ext = IEW'($signed(exp_i));

  // barrel shift toward bit LEAD, sticky on right shift
  always_comb begin
    lost   = 1'b0;
    shamt  = '0;
    mant_o = mant_i;
    if (lead_pos > LEAD_P) begin
      shamt  = lead_pos - LEAD_P;
      lost   = |(mant_i & ~({MANT_W{1'b1}} << shamt));
      mant_o = mant_i >> shamt;
      mant_o[0] = mant_o[0] | lost;
    end else begin
      shamt  = LEAD_P - lead_pos;
      mant_o = mant_i << shamt;
    end
    exp_o = zero_o ? exp_ext : (exp_ext + pos_s - LEAD_S);
  end

  // R2: a nonzero mantissa leaves with its leading one at bit LEAD
  assert_lead_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !zero_o) |-> (mant_o[LEAD] && (mant_o >> (LEAD + 1)) == '0));
endmodule

// File: rtl/dprp_rnd.sv
module dprp_rnd
  import dprp_pkg::*;
#(
  parameter int MANT_W = 64,
  parameter int IEW    = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chk_en,
  input  logic                  sign_i,
  input  logic signed [IEW-1:0] exp_i,
  input  logic [MANT_W-1:0]     mant_i,
  input  rmode_e                rmode_i,
  input  logic                  unf_trap_i,
  output logic signed [IEW-1:0] exp_o,
  output logic [FRAC_W:0]       sig_o,
  output logic                  inx_o,
  output logic                  unf_o
);
  localparam int SW = $clog2(MANT_W);
  localparam logic signed [IEW-1:0] EMIN_S   = IEW'(EMIN);
  localparam logic signed [IEW-1:0] REBIAS_S = IEW'(REBIAS);
  localparam logic signed [IEW-1:0] MANT_S   = IEW'(MANT_W);

  logic                  tiny;
  logic signed [IEW-1:0] amt;
  logic signed [IEW-1:0] exp_a;
  logic [SW-1:0]         sh;
  logic [MANT_W-1:0]     mant_d;
  logic                  trap_inx;
  logic                  lsb, grd, stk, low_nz, up;
  logic [FRAC_W+1:0]     sum;

  assign tiny = (exp_i < EMIN_S);

  // R8/R9: tiny-exponent handling
  always_comb begin
    exp_a    = exp_i;
    mant_d   = mant_i;
    unf_o    = 1'b0;
    trap_inx = 1'b0;
    amt      = EMIN_S - exp_i;
    sh       = amt[SW-1:0];
    if (tiny && unf_trap_i) begin
      exp_a    = exp_i + REBIAS_S;
      unf_o    = 1'b1;
      trap_inx = 1'b1;
    end else if (tiny) begin
      if (amt >= MANT_S) begin
        mant_d = {{(MANT_W-1){1'b0}}, |mant_i};
      end else begin
        mant_d    = mant_i >> sh;
        mant_d[0] = mant_d[0] | (|(mant_i & ~({MANT_W{1'b1}} << sh)));
      end
      exp_a = EMIN_S;
      unf_o = (mant_d[LEAD:GRS] == '0);
    end
  end

  // R3/R4: rounding decision
  always_comb begin
    lsb    = mant_d[GRS];
    grd    = mant_d[GRS-1];
    stk    = |mant_d[GRS-2:0];
    low_nz = |mant_d[GRS-1:0];
    unique case (rmode_i)
      RM_NEAR: up = grd & (stk | lsb);
      RM_ZERO: up = 1'b0;
      RM_PINF: up = ~sign_i & low_nz;
      default: up = sign_i & low_nz;
    endcase
    sum = {1'b0, mant_d[LEAD:GRS]} + (FRAC_W+2)'(up);
  end

  // R12: carry out of the mantissa bumps the exponent
  always_comb begin
    if (sum[FRAC_W+1]) begin
      sig_o = sum[FRAC_W+1:1];
      exp_o = exp_a + IEW'(1);
    end else begin
      sig_o = sum[FRAC_W:0];
      exp_o = exp_a;
    end
    inx_o = low_nz | trap_inx;
  end

  // R5: an exact in-range input passes its fraction through unchanged
  assert_exact_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !tiny && !inx_o) |-> (sig_o == mant_i[LEAD:GRS]));
endmodule

// File: rtl/dprp_pack.sv
module dprp_pack
  import dprp_pkg::*;
#(
  parameter int IEW = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chk_en,
  input  logic                  sign_i,
  input  logic                  zero_i,
  input  logic signed [IEW-1:0] exp_i,
  input  logic [FRAC_W:0]       sig_i,
  input  logic                  inx_i,
  input  logic                  unf_i,
  input  rmode_e                rmode_i,
  input  logic                  ovf_trap_i,
  output logic [RES_W-1:0]      res_o,
  output flags_t                flags_o
);
  localparam logic signed [IEW-1:0] EMAX_S   = IEW'(EMAX);
  localparam logic signed [IEW-1:0] BIAS_S   = IEW'(BIAS);
  localparam logic signed [IEW-1:0] REBIAS_S = IEW'(REBIAS);
  localparam logic [RES_W-2:0] INF_MAG = {{EF_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [RES_W-2:0] MAX_MAG = {{(EF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

  logic                  big;
  logic                  to_max;
  logic signed [IEW-1:0] exp_t;
  logic signed [IEW-1:0] fld;

  assign big = !zero_i && (exp_i > EMAX_S);

  always_comb begin
    unique case (rmode_i)
      RM_NEAR: to_max = 1'b0;
      RM_ZERO: to_max = 1'b1;
      RM_PINF: to_max = sign_i;
      default: to_max = ~sign_i;
    endcase
  end

  always_comb begin
    exp_t   = (big && ovf_trap_i) ? (exp_i - REBIAS_S) : exp_i;
    fld     = exp_t + BIAS_S;
    flags_o = '{ovf: 1'b0, unf: unf_i, inx: inx_i};
    res_o   = {sign_i, (sig_i[FRAC_W] ? fld[EF_W-1:0] : {EF_W{1'b0}}),
               sig_i[FRAC_W-1:0]};
    if (zero_i) begin
      res_o   = {sign_i, {(RES_W-1){1'b0}}};
      flags_o = '0;
    end else if (big) begin
      flags_o = '{ovf: 1'b1, unf: 1'b0, inx: 1'b1};
      if (!ovf_trap_i) res_o = {sign_i, (to_max ? MAX_MAG : INF_MAG)};
    end
  end

  // R6: untrapped overflow lands on the top two exponent codes only
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && big && !ovf_trap_i) |-> (res_o[RES_W-2 -: EF_W] >= {{(EF_W-1){1'b1}}, 1'b0}));
endmodule

// File: rtl/dp_round_pack.sv
module dp_round_pack
  import dprp_pkg::*;
#(
  parameter int MANT_W = 64,
  parameter int EXP_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic [1:0]        in_rmode,
  input  logic              in_ovf_trap,
  input  logic              in_unf_trap,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RES_W-1:0]  out_result,
  output logic [2:0]        out_flags
);
  localparam int IEW = EXP_W + 2;

  logic                  in_fire;
  logic [MANT_W-1:0]     n_mant;
  logic signed [IEW-1:0] n_exp;
  logic                  n_zero;
  logic signed [IEW-1:0] r_exp;
  logic [FRAC_W:0]       r_sig;
  logic                  r_inx, r_unf;
  logic [RES_W-1:0]      p_res;
  flags_t                p_flags;
  rmode_e                rm;
  logic                  valid_nxt;

  assign rm       = rmode_e'(in_rmode);
  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  dprp_norm #(.MANT_W(MANT_W), .EXP_W(EXP_W), .IEW(IEW)) u_norm (
    .clk(clk), .rst_n(rst_n), .chk_en(in_fire),
    .mant_i(in_mant), .exp_i(in_exp),
    .mant_o(n_mant), .exp_o(n_exp), .zero_o(n_zero)
  );

  dprp_rnd #(.MANT_W(MANT_W), .IEW(IEW)) u_rnd (
    .clk(clk), .rst_n(rst_n), .chk_en(in_fire),
    .sign_i(in_sign), .exp_i(n_exp), .mant_i(n_mant),
    .rmode_i(rm), .unf_trap_i(in_unf_trap),
    .exp_o(r_exp), .sig_o(r_sig), .inx_o(r_inx), .unf_o(r_unf)
  );

  dprp_pack #(.IEW(IEW)) u_pack (
    .clk(clk), .rst_n(rst_n), .chk_en(in_fire),
    .sign_i(in_sign), .zero_i(n_zero), .exp_i(r_exp), .sig_i(r_sig),
    .inx_i(r_inx), .unf_i(r_unf), .rmode_i(rm), .ovf_trap_i(in_ovf_trap),
    .res_o(p_res), .flags_o(p_flags)
  );

  always_comb begin
    valid_nxt = out_valid;
    if (in_fire)        valid_nxt = 1'b1;
    else if (out_ready) valid_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_nxt;
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      out_result <= p_res;
      out_flags  <= p_flags;
    end
  end

  // R13: accepted input shows up next cycle
  assert_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

  // R13: stalled output is held
  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)));

  // R11: zero mantissa gives a signed zero with clear flags
  assert_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_mant == '0) |=> (out_result[RES_W-2:0] == '0 && out_flags == 3'b000));
endmodule

// File: tb/sim_dp_round_pack.sv
module sim_dp_round_pack;
  localparam int MW = 64;
  localparam int EW = 13;

  logic          clk;
  logic          rst_n;
  logic          in_valid, in_ready, in_sign, in_ovf_trap, in_unf_trap;
  logic [EW-1:0] in_exp;
  logic [MW-1:0] in_mant;
  logic [1:0]    in_rmode;
  logic          out_valid, out_ready;
  logic [63:0]   out_result;
  logic [2:0]    out_flags;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  localparam logic [MW-1:0] ONE = 64'h0080_0000_0000_0000;

  dp_round_pack #(.MANT_W(MW), .EXP_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_rmode(in_rmode),
    .in_ovf_trap(in_ovf_trap), .in_unf_trap(in_unf_trap),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        fails++;
        $display("FAIL watchdog: run did not finish, got %0d cycles expected under 5000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic run(input string req, input logic s, input int e, input logic [MW-1:0] m,
                     input logic [1:0] rm, input logic ot, input logic ut,
                     input logic [63:0] exp_res, input logic [2:0] exp_flg);
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_exp = EW'(e); in_mant = m;
    in_rmode = rm; in_ovf_trap = ot; in_unf_trap = ut;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " result"}, out_result, exp_res);
    chk({req, " flags"}, {61'd0, out_flags}, {61'd0, exp_flg});
  endtask

  task automatic t_reset;
    chk("R14 out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk("R13 in_ready after reset", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_pack;
    run("R1 one", 0, 0, ONE, 2'd0, 0, 0, 64'h3FF0_0000_0000_0000, 3'b000);
    run("R1 neg frac", 1, 3, ONE | (64'd5 << 3), 2'd0, 0, 0, 64'hC020_0000_0000_0005, 3'b000);
  endtask

  task automatic t_norm;
    run("R2 right", 0, 0, ONE << 2, 2'd0, 0, 0, 64'h4010_0000_0000_0000, 3'b000);
    run("R2 right sticky", 0, 0, (ONE << 2) | 64'd1, 2'd0, 0, 0, 64'h4010_0000_0000_0000, 3'b001);
    run("R2 left", 0, 0, ONE >> 5, 2'd0, 0, 0, 64'h3FA0_0000_0000_0000, 3'b000);
  endtask

  task automatic t_round;
    run("R4 tie even", 0, 0, ONE | 64'h4, 2'd0, 0, 0, 64'h3FF0_0000_0000_0000, 3'b001);
    run("R4 tie odd", 0, 0, ONE | 64'hC, 2'd0, 0, 0, 64'h3FF0_0000_0000_0002, 3'b001);
    run("R3 chop", 0, 0, ONE | 64'h7, 2'd1, 0, 0, 64'h3FF0_0000_0000_0000, 3'b001);
    run("R3 plus inf", 0, 0, ONE | 64'h1, 2'd2, 0, 0, 64'h3FF0_0000_0000_0001, 3'b001);
    run("R3 minus inf neg", 1, 0, ONE | 64'h1, 2'd3, 0, 0, 64'hBFF0_0000_0000_0001, 3'b001);
    run("R5 nearest below half", 0, 0, ONE | 64'h3, 2'd0, 0, 0, 64'h3FF0_0000_0000_0000, 3'b001);
  endtask

  task automatic t_overflow;
    run("R6 near", 0, 1024, ONE, 2'd0, 0, 0, 64'h7FF0_0000_0000_0000, 3'b101);
    run("R6 chop", 0, 1024, ONE, 2'd1, 0, 0, 64'h7FEF_FFFF_FFFF_FFFF, 3'b101);
    run("R6 pinf neg", 1, 1024, ONE, 2'd2, 0, 0, 64'hFFEF_FFFF_FFFF_FFFF, 3'b101);
    run("R6 ninf neg", 1, 1024, ONE, 2'd3, 0, 0, 64'hFFF0_0000_0000_0000, 3'b101);
    run("R6 ninf pos", 0, 1024, ONE, 2'd3, 0, 0, 64'h7FEF_FFFF_FFFF_FFFF, 3'b101);
    run("R7 trap", 0, 1024, ONE, 2'd0, 1, 0, 64'h1FF0_0000_0000_0000, 3'b101);
  endtask

  task automatic t_carry;
    run("R12 carry", 0, 0, 64'h00FF_FFFF_FFFF_FFFF, 2'd0, 0, 0, 64'h4000_0000_0000_0000, 3'b001);
    run("R12 carry overflow", 0, 1023, 64'h00FF_FFFF_FFFF_FFFF, 2'd0, 0, 0, 64'h7FF0_0000_0000_0000, 3'b101);
  endtask

  task automatic t_underflow;
    run("R8 trap", 0, -1023, ONE, 2'd0, 0, 1, 64'h6000_0000_0000_0000, 3'b011);
    run("R9 exact denormal", 0, -1023, ONE, 2'd0, 0, 0, 64'h0008_0000_0000_0000, 3'b000);
    run("R9 denormal tie even", 0, -1023, ONE | 64'h8, 2'd0, 0, 0, 64'h0008_0000_0000_0000, 3'b001);
    run("R10 lost near", 0, -1100, ONE, 2'd0, 0, 0, 64'h0000_0000_0000_0000, 3'b011);
    run("R10 lost pinf", 0, -1100, ONE, 2'd2, 0, 0, 64'h0000_0000_0000_0001, 3'b011);
  endtask

  task automatic t_zero;
    run("R11 neg zero", 1, 50, 64'd0, 2'd2, 1, 1, 64'h8000_0000_0000_0000, 3'b000);
    run("R11 pos zero", 0, -2000, 64'd0, 2'd0, 0, 0, 64'h0000_0000_0000_0000, 3'b000);
  endtask

  task automatic t_handshake;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_sign = 0; in_exp = EW'(0); in_mant = ONE;
    in_rmode = 2'd0; in_ovf_trap = 0; in_unf_trap = 0;
    @(negedge clk);
    chk("R13 valid after accept", {63'd0, out_valid}, 64'd1);
    in_exp = EW'(1);
    chk("R13 ready low when full", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    chk("R13 held result", out_result, 64'h3FF0_0000_0000_0000);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R13 second result", out_result, 64'h4000_0000_0000_0000);
    @(negedge clk);
    chk("R13 drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_sign = 0; in_exp = '0; in_mant = '0; in_rmode = '0;
    in_ovf_trap = 0; in_unf_trap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pack();
    t_norm();
    t_round();
    t_overflow();
    t_carry();
    t_underflow();
    t_zero();
    t_handshake();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule